// File: doc/BRIEF.md
# Folded Symmetric Horizontal FIR Filter

This block filters a stream of 12-bit signed pixels along a line. Samples are loaded into an input register and then travel down a forward chain of seven programmable delay stages. The tail of that chain feeds a reverse chain of eight more stages. Tap pair k takes a forward sample delayed by k·L loads and a reverse sample delayed by (15−k)·L loads, where L is the programmable stage length. A small ALU combines each pair before one multiplier per pair. The eight products are summed into a registered result. This arrangement gives a 16-tap filter when the coefficients are symmetric and an 8-tap filter when they are not.

The stage length L runs from 1 to 16. Several interleaved data sets can then share one stream: L is set to the number of sets, and each set sees only its own samples. For decimation by N, L is set to N and a separate decimation field makes the valid strobe mark every N-th loaded sample. Loading is gated by a horizontal shift enable. In orthogonal mode a vertical shift enable must also be high.

Top module: `hfir_symfold`

## Requirements
- R1: After a synchronous reset, `dout` is 0 and `dout_valid` is 0, and every delay stage holds 0.
- R2: With `alu_sub`=0 and no operand forced to zero, the result is the sum over k=0..7 of coef_k·(x[m−k·L] + x[m−(15−k)·L]). Here x[m] is the most recently loaded sample, and coef_k is `coef[12k+11:12k]`, a signed value.
- R3: With `alu_sub`=1, each pair term is coef_k·(x[m−(15−k)·L] − x[m−k·L]), that is, the reverse operand minus the forward operand.
- R4: `alu_zero_fwd`=1 replaces the forward operand with 0, and `alu_zero_rev`=1 replaces the reverse operand with 0. Each gives an 8-tap asymmetric filter. With both set, the result is 0.
- R5: The stage length is L = `len_m1`+1, so code 0 gives length 1 and code 15 gives length 16.
- R6: A load happens on a clock edge when `hshift_en`=1 and either `ortho_mode`=0 or `vshift_en`=1. Without a load, the input register and all delay stages hold their values.
- R7: `dout_valid` marks every N-th load, where N = `decim_m1`+1. Loads are counted from reset, so the N-th load after reset is the first one marked.
- R8: The result for the window formed at a load edge appears on `dout` two clock edges after that edge. A valid mark appears on `dout_valid` in the same cycle. `dout` keeps tracking the current window on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 12 | Signed input sample |
| hshift_en | input | 1 | Horizontal shift enable |
| vshift_en | input | 1 | Vertical shift enable, used only in orthogonal mode |
| ortho_mode | input | 1 | 1: both shift enables are needed to load |
| alu_sub | input | 1 | 0: forward+reverse, 1: reverse−forward |
| alu_zero_fwd | input | 1 | Force the forward operand to 0 |
| alu_zero_rev | input | 1 | Force the reverse operand to 0 |
| len_m1 | input | 4 | Stage length minus one |
| decim_m1 | input | 4 | Decimation factor minus one |
| coef | input | 96 | Eight signed 12-bit coefficients, tap k at bits 12k+11:12k |
| dout | output | 28 | Signed filter result |
| dout_valid | output | 1 | Marks a decimated output sample |

## Verification
The hardest state to reach is a full pipeline at the longest stage length. At L=16 the outermost reverse tap lies 240 loads back. A stream of several hundred loads must therefore pass before every pair contributes, and each pair should carry a distinct value so that a misplaced tap shows up. The stimulus resets, selects length code 15 with decimation by 16, and drives a long random stream. Random enable gaps, including orthogonal mode with a toggling vertical enable, are added in separate phases. A behavioural history model in the bench predicts the result and the strobe on every clock.

// File: rtl/hfir_pkg.sv
package hfir_pkg;

    localparam int unsigned PIX_W   = 12;
    localparam int unsigned CF_W    = 12;
    localparam int unsigned N_PAIR  = 8;
    localparam int unsigned MAX_LEN = 16;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN);

    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_SUB = 1'b1
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    zero_fwd;
        logic    zero_rev;
    } alu_cfg_t;

endpackage

// File: rtl/hfir_delay.sv
module hfir_delay #(
    parameter int unsigned W     = 12,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] len_m1,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);

    logic [W-1:0] sr [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) sr[i] <= '0;
        end else if (en) begin
            sr[0] <= din;
            for (int i = 1; i < int'(DEPTH); i++) sr[i] <= sr[i-1];
        end
    end

    assign dout = sr[len_m1];

    // R6: a stage without a load keeps its output
    a_r6_stage_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(dout) || !$stable(len_m1)));

endmodule

// File: rtl/hfir_tap.sv
module hfir_tap
    import hfir_pkg::*;
#(
    parameter int unsigned DW = 12,
    parameter int unsigned CW = 12,
    parameter int unsigned SW = DW + 1,
    parameter int unsigned PW = SW + CW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  alu_cfg_t             cfg,
    input  logic [DW-1:0]        fwd,
    input  logic [DW-1:0]        rev,
    input  logic [CW-1:0]        coef,
    output logic signed [PW-1:0] prod
);

    logic signed [SW-1:0] op_a, op_b, pre;

    always_comb begin
        op_a = cfg.zero_fwd ? '0 : $signed({fwd[DW-1], fwd});
        op_b = cfg.zero_rev ? '0 : $signed({rev[DW-1], rev});
        pre  = (cfg.op == ALU_SUB) ? (op_b - op_a) : (op_a + op_b);
    end

    always_ff @(posedge clk) begin
        if (rst) prod <= '0;
        else     prod <= PW'(pre) * PW'($signed(coef));
    end

    // R4: with both operands forced off the pair contributes nothing
    a_r4_both_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg.zero_fwd && cfg.zero_rev) |=> (prod == '0));

endmodule

// File: rtl/hfir_decim.sv
module hfir_decim #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] decim_m1,
    output logic             vld
);

    logic [CNT_W-1:0] cnt;
    logic             v_stage, v_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            v_stage <= 1'b0;
            v_prod  <= 1'b0;
            vld     <= 1'b0;
        end else begin
            v_stage <= load && (cnt == decim_m1);
            v_prod  <= v_stage;
            vld     <= v_prod;
            if (load) cnt <= (cnt == decim_m1) ? '0 : cnt + 1'b1;
        end
    end

    // R8: every strobe traces back to a load three samples earlier
    a_r8_valid_from_load: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(load, 3));

endmodule

// File: rtl/hfir_symfold.sv
module hfir_symfold
    import hfir_pkg::*;
#(
    parameter int unsigned DATA_W = PIX_W,
    parameter int unsigned COEF_W = CF_W,
    parameter int unsigned PAIRS  = N_PAIR,
    parameter int unsigned MAXL   = MAX_LEN,
    parameter int unsigned L_W    = $clog2(MAXL),
    parameter int unsigned OUT_W  = DATA_W + 1 + COEF_W + $clog2(PAIRS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DATA_W-1:0]         din,
    input  logic                      hshift_en,
    input  logic                      vshift_en,
    input  logic                      ortho_mode,
    input  logic                      alu_sub,
    input  logic                      alu_zero_fwd,
    input  logic                      alu_zero_rev,
    input  logic [L_W-1:0]            len_m1,
    input  logic [L_W-1:0]            decim_m1,
    input  logic [PAIRS*COEF_W-1:0]   coef,
    output logic signed [OUT_W-1:0]   dout,
    output logic                      dout_valid
);

    localparam int unsigned SUM_W  = DATA_W + 1;
    localparam int unsigned PROD_W = SUM_W + COEF_W;

    logic                     load;
    logic [DATA_W-1:0]        din_q;
    logic [DATA_W-1:0]        fwd_tap [PAIRS];
    logic [DATA_W-1:0]        rev_tap [PAIRS];
    logic signed [PROD_W-1:0] prod    [PAIRS];
    logic signed [OUT_W-1:0]  acc;
    alu_cfg_t                 cfg;

    assign load = hshift_en && (!ortho_mode || vshift_en);
    assign cfg  = '{op: alu_op_e'(alu_sub), zero_fwd: alu_zero_fwd, zero_rev: alu_zero_rev};

    always_ff @(posedge clk) begin
        if (rst)       din_q <= '0;
        else if (load) din_q <= din;
    end

    assign fwd_tap[0] = din_q;

    for (genvar k = 1; k < int'(PAIRS); k++) begin : g_fwd
        hfir_delay #(.W(DATA_W), .DEPTH(MAXL), .SEL_W(L_W)) u_stage (
            .clk(clk), .rst(rst), .en(load), .len_m1(len_m1),
            .din(fwd_tap[k-1]), .dout(fwd_tap[k]));
    end

    for (genvar k = 0; k < int'(PAIRS); k++) begin : g_rev
        if (k == int'(PAIRS) - 1) begin : g_head
            hfir_delay #(.W(DATA_W), .DEPTH(MAXL), .SEL_W(L_W)) u_stage (
                .clk(clk), .rst(rst), .en(load), .len_m1(len_m1),
                .din(fwd_tap[PAIRS-1]), .dout(rev_tap[k]));
        end else begin : g_body
            hfir_delay #(.W(DATA_W), .DEPTH(MAXL), .SEL_W(L_W)) u_stage (
                .clk(clk), .rst(rst), .en(load), .len_m1(len_m1),
                .din(rev_tap[k+1]), .dout(rev_tap[k]));
        end
    end

    for (genvar k = 0; k < int'(PAIRS); k++) begin : g_tap
        hfir_tap #(.DW(DATA_W), .CW(COEF_W), .SW(SUM_W), .PW(PROD_W)) u_tap (
            .clk(clk), .rst(rst), .cfg(cfg),
            .fwd(fwd_tap[k]), .rev(rev_tap[k]),
            .coef(coef[k*COEF_W +: COEF_W]), .prod(prod[k]));
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < int'(PAIRS); k++)
            acc = acc + {{(OUT_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    end

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= acc;
    end

    hfir_decim #(.CNT_W(L_W)) u_decim (
        .clk(clk), .rst(rst), .load(load), .decim_m1(decim_m1), .vld(dout_valid));

    // R6: the input register holds when no load is granted
    a_r6_input_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(din_q));

    // R6: in orthogonal mode a low vertical enable blocks loading
    a_r6_ortho_block: assert property (@(posedge clk) disable iff (rst)
        (ortho_mode && !vshift_en) |=> $stable(din_q));

endmodule

// File: tb/hfir_symfold_tb.sv
`timescale 1ns/1ps
module hfir_symfold_tb;

    localparam int PAIRS = 8;
    localparam int CW    = 12;
    localparam int OW    = 28;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [11:0]           din = '0;
    logic                  hshift_en = 1'b0, vshift_en = 1'b0, ortho_mode = 1'b0;
    logic                  alu_sub = 1'b0, alu_zero_fwd = 1'b0, alu_zero_rev = 1'b0;
    logic [3:0]            len_m1 = '0, decim_m1 = '0;
    logic [PAIRS*CW-1:0]   coef = '0;
    logic signed [OW-1:0]  dout;
    logic                  dout_valid;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    hfir_symfold u_dut (
        .clk(clk), .rst(rst), .din(din),
        .hshift_en(hshift_en), .vshift_en(vshift_en), .ortho_mode(ortho_mode),
        .alu_sub(alu_sub), .alu_zero_fwd(alu_zero_fwd), .alu_zero_rev(alu_zero_rev),
        .len_m1(len_m1), .decim_m1(decim_m1), .coef(coef),
        .dout(dout), .dout_valid(dout_valid));

    always #4 clk = ~clk;

    // behavioural reference: sample history, newest at index 0
    int hist [256];
    int cf [PAIRS];
    longint psum_m, dout_m;
    bit v1, v2, vo;
    int cnt_m;

    function automatic longint window_sum();
        longint s = 0;
        int l = int'(len_m1) + 1;
        for (int k = 0; k < PAIRS; k++) begin
            int a = alu_zero_fwd ? 0 : hist[k*l];
            int b = alu_zero_rev ? 0 : hist[(15-k)*l];
            int p = alu_sub ? (b - a) : (a + b);
            s += longint'(cf[k]) * longint'(p);
        end
        return s;
    endfunction

    always @(posedge clk) begin
        bit ld;
        ld = hshift_en && (!ortho_mode || vshift_en);
        if (rst) begin
            for (int i = 0; i < 256; i++) hist[i] = 0;
            psum_m = 0; dout_m = 0; v1 = 0; v2 = 0; vo = 0; cnt_m = 0;
        end else begin
            dout_m = psum_m;
            vo = v2; v2 = v1;
            v1 = ld && (cnt_m == int'(decim_m1));
            if (ld) cnt_m = (cnt_m == int'(decim_m1)) ? 0 : (cnt_m + 1) % 16;
            psum_m = window_sum();
            if (ld) begin
                for (int i = 255; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = int'($signed(din));
            end
        end
    end

    task automatic check_now();
        checks++;
        if (longint'(dout) != dout_m || dout_valid != vo) begin
            errors++;
            $display("FAIL %s: dout=%0d valid=%0b expected dout=%0d valid=%0b",
                     cur_req, dout, dout_valid, dout_m, vo);
        end
    endtask

    task automatic set_coefs();
        for (int k = 0; k < PAIRS; k++) begin
            cf[k] = $urandom_range(0, 4095) - 2048;
            coef[k*CW +: CW] = cf[k][11:0];
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; hshift_en = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    // n cycles: compare at negedge then drive; hp/vp: percent enables high
    task automatic run(int n, int hp, int vp);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
            din       = 12'($urandom_range(0, 4095));
            hshift_en = ($urandom_range(0, 99) < hp);
            vshift_en = ($urandom_range(0, 99) < vp);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: expired, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        set_coefs();
        do_reset();
        // R1: reset state
        cur_req = "R1";
        @(negedge clk); check_now();
        checks++;
        if (dout !== '0 || dout_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: dout=%0d valid=%0b expected 0 0", dout, dout_valid);
        end

        // R2: even symmetric, length 1
        cur_req = "R2"; run(80, 100, 0);
        // R3: odd symmetric
        cur_req = "R3"; alu_sub = 1'b1; run(60, 100, 0);
        // R4: forward only, reverse only, both forced off
        cur_req = "R4"; alu_sub = 1'b0; alu_zero_rev = 1'b1; run(40, 100, 0);
        alu_zero_rev = 1'b0; alu_zero_fwd = 1'b1; run(40, 100, 0);
        alu_zero_rev = 1'b1; run(20, 100, 0);
        alu_zero_fwd = 1'b0; alu_zero_rev = 1'b0;

        // R1 again mid-stream, then R5/R7 with length 3, decimate by 3
        do_reset(); cur_req = "R1"; run(3, 0, 0);
        len_m1 = 4'd2; decim_m1 = 4'd2;
        cur_req = "R5"; run(120, 100, 0);
        cur_req = "R7"; run(60, 100, 0);

        // R5 boundary: length 16, decimate by 16
        do_reset(); set_coefs();
        len_m1 = 4'd15; decim_m1 = 4'd15;
        cur_req = "R5"; run(320, 100, 0);
        alu_sub = 1'b1; run(40, 100, 0); alu_sub = 1'b0;

        // R6: gaps in horizontal enable, then orthogonal mode
        do_reset(); len_m1 = 4'd1; decim_m1 = 4'd3;
        cur_req = "R6"; run(200, 60, 0);
        ortho_mode = 1'b1; run(200, 80, 50);
        ortho_mode = 1'b0;

        // R8: impulse through a single forward tap, latency check
        do_reset(); len_m1 = 4'd0; decim_m1 = 4'd0;
        alu_zero_rev = 1'b1;
        for (int k = 0; k < PAIRS; k++) begin cf[k] = (k == 0) ? 1 : 0; coef[k*CW +: CW] = cf[k][11:0]; end
        cur_req = "R8";
        @(negedge clk); din = 12'd100; hshift_en = 1'b1;
        @(negedge clk); hshift_en = 1'b0; check_now();
        checks++;
        if (dout != 0 || dout_valid) begin
            errors++; $display("FAIL R8: edge+0 dout=%0d valid=%0b expected 0 0", dout, dout_valid);
        end
        @(negedge clk); check_now();
        checks++;
        if (dout != 0 || dout_valid) begin
            errors++; $display("FAIL R8: edge+1 dout=%0d valid=%0b expected 0 0", dout, dout_valid);
        end
        @(negedge clk); check_now();
        checks++;
        if (dout != 100 || !dout_valid) begin
            errors++; $display("FAIL R8: edge+2 dout=%0d valid=%0b expected 100 1", dout, dout_valid);
        end
        @(negedge clk); check_now();
        checks++;
        if (dout != 100 || dout_valid) begin
            errors++; $display("FAIL R8: edge+3 dout=%0d valid=%0b expected 100 0", dout, dout_valid);
        end
        alu_zero_rev = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule